// File: doc/BRIEF.md
# Serial Bit-Clock Divider Solver

This unit works out the settings for a serial bit-clock generator. The generator's output rate is the input clock divided by an even prescale and by one plus an 8-bit rate divider. A request gives the input clock frequency, the wanted bit rate and whether the port acts as clock master or clock follower. A one-cycle `start` pulse launches the request. The unit answers with a one-cycle `done` pulse. With that pulse it raises either `ok`, with a prescale and a rate divider, or `err`.

The unit first checks that the request is legal. A legal request then costs one division of the input clock by the bit rate, which gives the ratio. After that comes a search upward over even prescales. Each step divides the ratio by the candidate prescale. The search stops at the first prescale whose quotient minus one fits in 8 bits. All divisions share one restoring divider that produces one quotient bit per cycle.

Top module: `rate_solver`

## Requirements
- R1: In master mode (`slave`=0), a request whose bit rate exceeds half the input clock (2·`bit_hz` > `in_hz`) is rejected: `done` rises one cycle after the accepted `start` with `err`=1, `ok`=0, `prescale`=0 and `rate_div`=0.
- R2: In follower mode (`slave`=1), a request is rejected in the same way as in R1 when 12·`bit_hz` > `in_hz`.
- R3: A request with `bit_hz`=0 is rejected in the same way as in R1, in either mode, and starts no division.
- R4: For a legal request, with ratio = floor(`in_hz`/`bit_hz`), the result is the smallest even prescale p ≥ 2 for which floor(ratio/p) − 1 ≤ 255. The outputs are `ok`=1, `err`=0, `prescale`=p and `rate_div`=floor(ratio/p) − 1.
- R5: If no even prescale up to `PS_MAX` satisfies R4, the result is `err`=1, `ok`=0, `prescale`=0 and `rate_div`=0.
- R6: `done` is high for exactly one cycle per request. In that cycle exactly one of `ok` and `err` is high.
- R7: `ok`, `err`, `prescale` and `rate_div` keep their last result from one `done` until the next `done`.
- R8: `start` is accepted in the cycle where `done` is high, so requests can follow each other with no idle cycle. `start` is ignored while a computation is running.
- R9: After reset, `done`, `ok`, `err`, `prescale` and `rate_div` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| in_hz | input | W | Input clock frequency |
| bit_hz | input | W | Requested bit rate |
| slave | input | 1 | 1 = follower-mode limit, 0 = master-mode limit |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Last result is a valid setting |
| err | output | 1 | Last request was rejected or unsolvable |
| prescale | output | 8 | Even prescale result |
| rate_div | output | 8 | Rate divider result |

## Verification
Two things can fall in the same cycle: a completion, and the acceptance of the next request. The bench always drives the next `start` in the very cycle where it sees `done`. One edge later it judges two things. The first is `done` itself: it must be low for a legal request and high again for one rejected at once. The second is the set of result outputs: they must still show the previous answer while the new computation runs. A sweep covers both modes across many clock and rate pairs. It includes the exact legality limits, the prescale boundary where the rate divider is exactly 255, and ratios that no prescale up to the limit can reach. Every result is compared with the arithmetic model in the bench.

// File: rtl/rate_solver.sv
module rate_solver #(
  parameter int W      = 16,
  parameter int PS_MAX = 254
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] in_hz,
  input  logic [W-1:0] bit_hz,
  input  logic         slave,
  output logic         done,
  output logic         ok,
  output logic         err,
  output logic [7:0]   prescale,
  output logic [7:0]   rate_div
);
  localparam int CW = $clog2(W + 1);

  logic          busy, ph_ps;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rem, quo, dsr, ratio;
  logic [7:0]    ps;

  logic [W:0]    sh;
  logic [W-1:0]  diff, qn, rn;
  logic          fit, bad, last, settle;
  logic [8:0]    ps_nx;

  assign sh     = {rem, quo[W-1]};
  assign fit    = sh >= {1'b0, dsr};
  assign diff   = sh[W-1:0] - dsr;
  assign qn     = {quo[W-2:0], fit};
  assign rn     = fit ? diff : sh[W-1:0];
  assign last   = busy && (cnt == CW'(1));
  assign settle = last && ph_ps && (qn != '0) && (qn <= W'(256));
  assign ps_nx  = {1'b0, ps} + 9'd2;

  assign bad = (bit_hz == '0) ||
               (slave ? (({4'b0, bit_hz} * (W+4)'(12)) > {4'b0, in_hz})
                      : ({bit_hz, 1'b0} > {1'b0, in_hz}));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; ph_ps <= 1'b0; cnt <= '0;
      rem <= '0; quo <= '0; dsr <= '0; ratio <= '0; ps <= '0;
      done <= 1'b0; ok <= 1'b0; err <= 1'b0;
      prescale <= '0; rate_div <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (bad) begin
            done <= 1'b1; ok <= 1'b0; err <= 1'b1;
            prescale <= '0; rate_div <= '0;
          end else begin
            busy <= 1'b1; ph_ps <= 1'b0; cnt <= CW'(W);
            rem <= '0; quo <= in_hz; dsr <= bit_hz;
          end
        end
      end else begin
        rem <= rn;
        quo <= qn;
        cnt <= cnt - CW'(1);
        if (last) begin
          rem <= '0;
          cnt <= CW'(W);
          if (!ph_ps) begin
            ratio <= qn; quo <= qn; dsr <= W'(2); ps <= 8'd2; ph_ps <= 1'b1;
          end else if (settle) begin
            busy <= 1'b0; done <= 1'b1; ok <= 1'b1; err <= 1'b0;
            prescale <= ps; rate_div <= 8'(qn - W'(1));
          end else if (ps_nx > 9'(PS_MAX)) begin
            busy <= 1'b0; done <= 1'b1; ok <= 1'b0; err <= 1'b1;
            prescale <= '0; rate_div <= '0;
          end else begin
            ps <= ps_nx[7:0]; quo <= ratio; dsr <= W'(ps_nx);
          end
        end
      end
    end
  end

  assert_master_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !slave && (bit_hz != '0) && ({bit_hz, 1'b0} > {1'b0, in_hz})
    |=> done && err && !ok);

  assert_zero_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && (bit_hz == '0) |=> done && err && !busy);

  assert_ok_prescale_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok |-> !prescale[0] && (prescale >= 8'd2) && (32'(prescale) <= PS_MAX));

  assert_single_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);

  assert_one_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok ^ err));

  assert_hold_results_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable({ok, err, prescale, rate_div}));
endmodule

// File: tb/rate_solver_bench.sv
module rate_solver_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int PS_MAX = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, slave = 1'b0;
  logic [W-1:0] in_hz = '0, bit_hz = '0;
  logic done, ok, err;
  logic [7:0] prescale, rate_div;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit p_ok = 0, p_err = 0;
  int p_ps = 0, p_dv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_solver #(.W(W), .PS_MAX(PS_MAX)) u_rate_solver (
    .clk(clk), .rst_n(rst_n), .start(start), .in_hz(in_hz), .bit_hz(bit_hz),
    .slave(slave), .done(done), .ok(ok), .err(err),
    .prescale(prescale), .rate_div(rate_div));

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(input int c, input int r, input bit s,
                       output bit e_ok, output bit e_err, output bit imm,
                       output int e_ps, output int e_dv);
    int ratio;
    imm = (r == 0) || (s ? (12*r > c) : (2*r > c));
    e_ok = 0; e_err = 1; e_ps = 0; e_dv = 0;
    if (!imm) begin
      ratio = c / r;
      for (int p = 2; p <= PS_MAX; p += 2) begin
        if (ratio / p - 1 <= 255) begin
          e_ok = 1; e_err = 0; e_ps = p; e_dv = ratio / p - 1;
          break;
        end
      end
    end
  endtask

  task automatic issue(input int c, input int r, input bit s);
    bit e_ok, e_err, imm;
    int e_ps, e_dv, wd;
    string tag;
    model(c, r, s, e_ok, e_err, imm, e_ps, e_dv);
    tag = (r == 0) ? "R3" : imm ? (s ? "R2" : "R1") : e_ok ? "R4" : "R5";
    in_hz = W'(c); bit_hz = W'(r); slave = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (imm) begin
      chk(done === 1'b1, tag, int'(done), 1);
    end else begin
      chk(done === 1'b0, "R6 R8", int'(done), 0);
      chk({ok, err} === {p_ok, p_err} && prescale == p_ps && rate_div == p_dv,
          "R7", {ok, err, prescale, rate_div}, {p_ok, p_err, 8'(p_ps), 8'(p_dv)});
    end
    wd = 0;
    while (done !== 1'b1 && wd < 2000) begin
      @(negedge clk);
      wd++;
    end
    chk(done === 1'b1, "R6 watchdog", int'(done), 1);
    chk(ok === e_ok && err === e_err, tag, {ok, err}, {e_ok, e_err});
    chk(prescale == e_ps && rate_div == e_dv, tag, {prescale, rate_div}, {8'(e_ps), 8'(e_dv)});
    p_ok = e_ok; p_err = e_err; p_ps = e_ps; p_dv = e_dv;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int clks[13] = '{0, 1, 11, 12, 13, 24, 100, 513, 514, 1030, 2048, 2049, 4095};
    int big[8] = '{100, 255, 256, 511, 1024, 2047, 2048, 4095};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({done, ok, err} === 3'b000 && prescale == 0 && rate_div == 0, "R9",
        {done, ok, err, prescale, rate_div}, 0);
    issue(4095, 1, 0);
    issue(2049, 1, 0);
    issue(24, 2, 1);
    issue(24, 3, 1);
    issue(24, 12, 0);
    issue(24, 13, 0);
    issue(500, 0, 1);
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 13; i++) begin
        for (int r = 0; r <= 20; r++) issue(clks[i], r, s[0]);
        for (int k = 0; k < 8; k++) issue(clks[i], big[k], s[0]);
      end
    @(negedge clk);
    chk(done === 1'b0, "R6", int'(done), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule